// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port with Optional FIFOs

This block is a byte-wide serial port for a host on a simple parallel bus. The host selects one of eight byte registers with a 3-bit address. It writes a register by asserting chip select and the write strobe for one clock. It reads a register by asserting chip select and the read strobe for one clock. Read data is valid during that cycle. A 16x oversampling baud generator drives a transmitter and a receiver. The serial frame is fixed at 8 data bits, no parity and one stop bit.

Each direction buffers characters in a storage element. That element is either a 16-entry FIFO or, with the FIFOs switched off, a single holding register. A bit in the line-control register switches two addresses from the data and interrupt-enable registers to the two bytes of the baud divisor. The host polls line status or uses the interrupt output. Interrupt identification reports the highest-priority pending source.

Top module: `uart16_core`

## Requirements
- R1: After reset the serial output is high, line status (offset 5) reads 0x60, interrupt identification (offset 2) reads 0x01, and every other register reads 0x00.
- R2: When line-control bit 7 is set, offset 0 accesses the divisor low byte and offset 1 the divisor high byte. When it is clear, offset 0 is the data register and offset 1 is interrupt enable (bit 0 receive, bit 1 transmit). Line control (offset 3), modem control (offset 4, 5 bits) and scratch (offset 7) read back what was written.
- R3: One serial bit lasts 16 × divisor clock cycles. A divisor of 0 halts both the transmitter and the receiver.
- R4: One write to the data register produces exactly one frame: a low start bit, 8 data bits least significant first, then a high stop bit.
- R5: With the FIFOs off (FIFO control bit 0 = 0), the receiver holds one character. A character that completes while it is held is dropped and sets line-status bit 1. That bit clears when line status is read.
- R6: With the FIFOs on, 16 received characters are kept and read back in arrival order. A 17th sets the overrun bit.
- R7: A read of offset 0 with line-control bit 7 clear removes one received character. Line-status bit 0 stays set until the receive storage is empty.
- R8: A write to FIFO control with bit 1 set empties the receive storage, and with bit 2 set empties the transmit storage. These bits do not persist, so reception continues normally afterwards.
- R9: Line-status bit 5 is set while the transmit storage can accept a character. Bit 6 is set only when both the transmit storage and the shift register are empty.
- R10: A low stop bit still delivers the character and sets line-status bit 3. That bit clears when line status is read.
- R11: Interrupt identification reads 0x04 when receive data is at or above the trigger level with bit 0 enabled. It reads 0x02 when transmit storage is empty with bit 1 enabled. It reads 0x01 otherwise, and receive takes priority. Bits 7:6 read 11 when the FIFOs are on. FIFO control bits 7:6 select a trigger of 1, 4, 8 or 14 characters (only 1 with the FIFOs off). The interrupt output is high whenever a source is pending.
- R12: A start bit is confirmed at the 8th oversampling tick. A low pulse shorter than half a bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the baud reference |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe, one cycle per access |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| sin | input | 1 | Serial input |
| sout | output | 1 | Serial output |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches four things on every cycle:
- transmit and receive occupancy never exceed the capacity of the selected mode;
- a lost character always raises the overrun flag;
- the transmitter-empty bit never appears without the can-accept bit;
- the serial output freezes while the divisor is zero.

It also checks that a data read drains a single held character and that no interrupt is raised without an enable. Frame timing and bit order, divisor banking, FIFO ordering, trigger levels, flag clearing on read, and rejection of short start pulses depend on whole serial sequences. Only the bench scenarios can show them.

// File: rtl/uart16_pkg.sv
// Package: register offsets, state encodings and the receive trigger decode
// shared by the serial port modules.
package uart16_pkg;

    localparam logic [2:0] OFS_DATA  = 3'd0;
    localparam logic [2:0] OFS_IEN   = 3'd1;
    localparam logic [2:0] OFS_IDFC  = 3'd2;
    localparam logic [2:0] OFS_LCTL  = 3'd3;
    localparam logic [2:0] OFS_MCTL  = 3'd4;
    localparam logic [2:0] OFS_LSTAT = 3'd5;
    localparam logic [2:0] OFS_MSTAT = 3'd6;
    localparam logic [2:0] OFS_SCR   = 3'd7;

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

    // Receive trigger level in characters for a FIFO-control selector.
    function automatic int trig_level(input logic fifo_on, input logic [1:0] sel);
        if (!fifo_on) return 1;
        case (sel)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/uart16_baud.sv
// Baud tick generator: emits a one-cycle tick every DIVISOR clocks. That gives
// 16 ticks per serial bit. A divisor of zero stops the ticks.
// Assumes the divisor is changed only while the line is quiet.
module uart16_baud #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DIVW-1:0] divisor,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    // Count clocks up to divisor-1 and pulse tick on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || divisor == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= divisor - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/uart16_fifo.sv
// Character storage: a DEPTH-entry circular FIFO. With single set, it acts
// as a one-entry holding register. Pushes when full and pops when empty
// are dropped. Assumes DEPTH is a power of two, so the pointers wrap naturally.
module uart16_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          single,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = single ? (count != '0) : (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    // Store an accepted character at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Track pointers and occupancy; clear empties the storage.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/uart16_tx.sv
// Transmitter: on a baud tick, when a character is waiting it takes the
// character and sends start, 8 data bits LSB first and a stop bit. Each bit
// lasts 16 ticks. Starting on a tick makes every bit exactly 16 ticks long.
module uart16_tx
    import uart16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       have,
    input  logic [7:0] data,
    output logic       take,
    output logic       sout,
    output logic       busy
);
    tx_state_e  st;
    logic [9:0] frame;
    logic [3:0] tcnt;
    logic [3:0] bitn;

    assign take = (st == TX_IDLE) && tick && have;
    assign busy = (st == TX_SEND);
    assign sout = (st == TX_SEND) ? frame[0] : 1'b1;

    // Load a frame when idle, then shift one bit out every 16 ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            frame <= '1;
            tcnt  <= '0;
            bitn  <= '0;
        end else if (take) begin
            st    <= TX_SEND;
            frame <= {1'b1, data, 1'b0};
            tcnt  <= '0;
            bitn  <= '0;
        end else if (st == TX_SEND && tick) begin
            if (tcnt == 4'd15) begin
                tcnt  <= '0;
                frame <= {1'b1, frame[9:1]};
                if (bitn == 4'd9) st <= TX_IDLE;
                else              bitn <= bitn + 1'b1;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart16_rx.sv
// Receiver: synchronises the serial input and waits for a falling edge. It
// confirms the start bit 8 ticks later, then samples each data bit and the
// stop bit 16 ticks apart. Each finished frame gives a one-cycle done pulse
// with the byte and a framing flag.
module uart16_rx
    import uart16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       sin,
    output logic       done,
    output logic [7:0] data,
    output logic       ferr
);
    rx_state_e st;
    logic      s1, s2, prev;
    logic [3:0] tcnt;
    logic [2:0] bitn;

    // Two-flop synchroniser plus edge history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
        end else begin
            s1 <= sin; s2 <= s1; prev <= s2;
        end
    end

    // Frame state machine: edge detect, start confirm, data and stop sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RX_IDLE;
            tcnt <= '0;
            bitn <= '0;
            data <= '0;
            done <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                RX_IDLE: if (prev && !s2) begin
                    st   <= RX_START;
                    tcnt <= '0;
                end
                RX_START: if (tick) begin
                    if (tcnt == 4'd7) begin
                        tcnt <= '0;
                        bitn <= '0;
                        st   <= s2 ? RX_IDLE : RX_DATA;
                    end else tcnt <= tcnt + 1'b1;
                end
                RX_DATA: if (tick) begin
                    if (tcnt == 4'd15) begin
                        tcnt <= '0;
                        data <= {s2, data[7:1]};
                        if (bitn == 3'd7) st <= RX_STOP;
                        else              bitn <= bitn + 1'b1;
                    end else tcnt <= tcnt + 1'b1;
                end
                default: if (tick) begin
                    if (tcnt == 4'd15) begin
                        done <= 1'b1;
                        ferr <= !s2;
                        st   <= RX_IDLE;
                    end else tcnt <= tcnt + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/uart16_core.sv
// Serial port top: the register file on the host bus, with a bank bit that
// swaps in the divisor bytes. It holds the FIFO-control decode, line status
// and interrupt identification, and instances the baud generator, both
// storage FIFOs, the transmitter and the receiver. Bus strobes are one-cycle
// pulses sampled on the rising clock edge.
module uart16_core
    import uart16_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rd,
    input  logic       wr,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       sin,
    output logic       sout,
    output logic       irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [7:0] div_lo, div_hi, lctl, scratch;
    logic [3:0] ien;
    logic [4:0] mctl;
    logic       fifo_on, ovr, ferr_q;
    logic [1:0] trig_sel;
    logic [15:0] divisor;
    logic       dlab, wr_en, rd_en;
    logic       tick;
    logic       rx_clr, tx_clr;
    logic       rx_done, rx_ferr;
    logic [7:0] rx_byte, rx_head, tx_head;
    logic [CW-1:0] rx_count, tx_count;
    logic       rx_empty, rx_full, tx_empty, tx_full;
    logic       tx_take, tx_busy, rx_pop, tx_push, lsr_read;
    logic       rx_int, tx_int;
    logic [7:0] lsr, iir;

    assign divisor  = {div_hi, div_lo};
    assign dlab     = lctl[7];
    assign wr_en    = cs && wr;
    assign rd_en    = cs && rd;
    assign tx_push  = wr_en && addr == OFS_DATA && !dlab;
    assign rx_pop   = rd_en && addr == OFS_DATA && !dlab;
    assign lsr_read = rd_en && addr == OFS_LSTAT;
    assign rx_clr   = wr_en && addr == OFS_IDFC && (wdata[1] || (wdata[0] != fifo_on));
    assign tx_clr   = wr_en && addr == OFS_IDFC && (wdata[2] || (wdata[0] != fifo_on));

    // Host-written registers; FIFO-control clear bits act once and are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= '0; div_hi <= '0; lctl <= '0; scratch <= '0;
            ien <= '0; mctl <= '0; fifo_on <= 1'b0; trig_sel <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_DATA: if (dlab) div_lo <= wdata;
                OFS_IEN:  if (dlab) div_hi <= wdata; else ien <= wdata[3:0];
                OFS_IDFC: begin
                    fifo_on  <= wdata[0];
                    trig_sel <= wdata[7:6];
                end
                OFS_LCTL: lctl    <= wdata;
                OFS_MCTL: mctl    <= wdata[4:0];
                OFS_SCR:  scratch <= wdata;
                default: ;
            endcase
        end
    end

    // Sticky error flags: a new error wins over a clear on the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr    <= 1'b0;
            ferr_q <= 1'b0;
        end else begin
            if (rx_done && rx_full)      ovr <= 1'b1;
            else if (lsr_read)           ovr <= 1'b0;
            if (rx_done && rx_ferr)      ferr_q <= 1'b1;
            else if (lsr_read)           ferr_q <= 1'b0;
        end
    end

    // Status and identification composed from storage and engine state.
    always_comb begin
        lsr    = {1'b0, tx_empty && !tx_busy, !tx_full, 1'b0, ferr_q, 1'b0, ovr, !rx_empty};
        rx_int = ien[0] && (int'(rx_count) >= trig_level(fifo_on, trig_sel));
        tx_int = ien[1] && tx_empty;
        iir    = {fifo_on, fifo_on, 6'h01};
        if (rx_int)      iir[3:0] = 4'h4;
        else if (tx_int) iir[3:0] = 4'h2;
    end

    assign irq = rx_int || tx_int;

    // Read-data multiplexer, driven only during a selected read.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_DATA:  rdata = dlab ? div_lo : rx_head;
                OFS_IEN:   rdata = dlab ? div_hi : {4'h0, ien};
                OFS_IDFC:  rdata = iir;
                OFS_LCTL:  rdata = lctl;
                OFS_MCTL:  rdata = {3'b000, mctl};
                OFS_LSTAT: rdata = lsr;
                OFS_MSTAT: rdata = '0;
                default:   rdata = scratch;
            endcase
        end
    end

    uart16_baud #(.DIVW(16)) u_baud (
        .clk(clk), .rst_n(rst_n), .divisor(divisor), .tick(tick)
    );

    uart16_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(tx_clr), .single(!fifo_on),
        .push(tx_push), .din(wdata), .pop(tx_take), .dout(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    uart16_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(rx_clr), .single(!fifo_on),
        .push(rx_done), .din(rx_byte), .pop(rx_pop), .dout(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    uart16_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .have(!tx_empty), .data(tx_head),
        .take(tx_take), .sout(sout), .busy(tx_busy)
    );

    uart16_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sin(sin),
        .done(rx_done), .data(rx_byte), .ferr(rx_ferr)
    );
endmodule

// File: rtl/uart16_core_chk.sv
// Checker for uart16_core: cross-checks the bus, storage occupancy, status
// bits and the serial output on every clock. It is bound into the top module.
module uart16_core_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs,
    input logic          rd,
    input logic [2:0]    addr,
    input logic          dlab,
    input logic          sout,
    input logic          irq,
    input logic [3:0]    ien,
    input logic [15:0]   divisor,
    input logic          fifo_on,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_done,
    input logic          rx_full,
    input logic [7:0]    lsr
);
    // R6: occupancy stays within the capacity of the selected mode.
    a_r6_tx_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tx_count) <= (fifo_on ? DEPTH : 1));
    a_r6_rx_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_count) <= (fifo_on ? DEPTH : 1));

    // R7: reading the only held character empties the receive storage.
    a_r7_pop_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 3'd0 && !dlab && rx_count == CW'(1) && !rx_done) |=> rx_count == '0);

    // R5: a character finishing into full storage raises overrun.
    a_r5_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_full) |=> lsr[1]);

    // R9: transmitter-empty never appears without can-accept.
    a_r9_temt_thre: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[6] |-> lsr[5]);

    // R3: with the divisor held at zero the serial output is frozen.
    a_r3_zero_div_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0 && $past(divisor) == '0) |=> $stable(sout));

    // R11: no interrupt without an enabled source.
    a_r11_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien[1:0] != 2'b00));
endmodule

bind uart16_core uart16_core_chk #(.DEPTH(FIFO_DEPTH), .CW($clog2(FIFO_DEPTH + 1))) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .addr(addr), .dlab(dlab),
    .sout(sout), .irq(irq), .ien(ien), .divisor(divisor), .fifo_on(fifo_on),
    .rx_count(rx_count), .tx_count(tx_count), .rx_done(rx_done),
    .rx_full(rx_full), .lsr(lsr)
);

// File: tb/uart16_core_bench.sv
// Bench for uart16_core: a register table walk, then directed serial scenarios.
module uart16_core_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NTBL = 13;
    localparam int BITCLK = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic sin = 1'b1;
    logic sout, irq;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    uart16_core u_uart16_core (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sin(sin), .sout(sout), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {is_write(4b), offset(4b), data(8b), expected read(8b)}
    localparam logic [23:0] TBL [NTBL] = '{
        24'h1_7_A5_00, 24'h0_7_00_A5,          // R2 scratch
        24'h1_3_83_00, 24'h1_0_01_00, 24'h1_1_00_00,
        24'h0_0_00_01, 24'h0_1_00_00, 24'h0_3_00_83, // R2 divisor bank
        24'h1_3_03_00, 24'h0_3_00_03, 24'h0_1_00_00,
        24'h1_4_1F_00, 24'h0_4_00_1F             // R2 modem control
    };

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd = 1; addr = a;
        #1 d = rdata;
        @(negedge clk); cs = 0; rd = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic ser_send(input logic [7:0] b, input logic stopv);
        logic [9:0] f;
        f = {stopv, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            sin = f[i];
            repeat (BITCLK) @(negedge clk);
        end
        sin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic get_frame(output logic [7:0] b, output logic ok);
        int n;
        n = 0; ok = 1'b1; b = '0;
        while (sout !== 1'b0 && n < 4000) begin @(negedge clk); n++; end
        if (n >= 4000) ok = 1'b0;
        repeat (BITCLK/2) @(negedge clk);
        if (sout !== 1'b0) ok = 1'b0;
        for (int i = 0; i < 8; i++) begin
            repeat (BITCLK) @(negedge clk);
            b[i] = sout;
        end
        repeat (BITCLK) @(negedge clk);
        if (sout !== 1'b1) ok = 1'b0;
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog got hung exp done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic ok;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sout", {7'd0, sout}, 8'h01);
        rd_chk("R1 lsr", 3'd5, 8'h60);
        rd_chk("R1 iir", 3'd2, 8'h01);
        rd_chk("R1 ier", 3'd1, 8'h00);
        rd_chk("R1 lcr", 3'd3, 8'h00);
        rd_chk("R1 mcr", 3'd4, 8'h00);
        rd_chk("R1 msr", 3'd6, 8'h00);
        rd_chk("R1 scr", 3'd7, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 table walk (leaves divisor = 1, 8N1)
        for (int i = 0; i < NTBL; i++) begin
            if (TBL[i][23:20] != 0) bus_wr(TBL[i][18:16], TBL[i][15:8]);
            else rd_chk("R2 table", TBL[i][18:16], TBL[i][7:0]);
        end
        bus_wr(3'd4, 8'h00);

        // R4 / R9 single frame, FIFOs off
        bus_wr(3'd0, 8'hA3);
        rd_chk("R9 busy temt", 3'd5, 8'h20);
        get_frame(v, ok);
        chk("R4 frame ok", {7'd0, ok}, 8'h01);
        chk("R4 frame data", v, 8'hA3);
        n = 0;
        for (int i = 0; i < 400; i++) begin @(negedge clk); if (sout === 1'b0) n++; end
        chk("R4 one frame only", n[7:0], 8'h00);
        rd_chk("R9 idle lsr", 3'd5, 8'h60);

        // R3 bit length with divisor 2
        bus_wr(3'd3, 8'h83); bus_wr(3'd0, 8'h02); bus_wr(3'd3, 8'h03);
        bus_wr(3'd0, 8'h55);
        n = 0;
        while (sout !== 1'b0 && n < 2000) begin @(negedge clk); n++; end
        n = 0;
        while (sout === 1'b0 && n < 2000) begin n++; @(negedge clk); end
        chk("R3 start bit cycles", n[7:0], 8'd32);
        repeat (400) @(negedge clk);
        bus_wr(3'd3, 8'h83); bus_wr(3'd0, 8'h01); bus_wr(3'd3, 8'h03);

        // R5 overrun with one-character holding
        ser_send(8'h41, 1'b1);
        ser_send(8'h42, 1'b1);
        rd_chk("R5 lsr overrun", 3'd5, 8'h63);
        rd_chk("R5 first kept", 3'd0, 8'h41);
        rd_chk("R5 overrun cleared", 3'd5, 8'h60);

        // R10 framing error
        ser_send(8'h5A, 1'b0);
        rd_chk("R10 lsr ferr", 3'd5, 8'h69);
        rd_chk("R10 data", 3'd0, 8'h5A);
        rd_chk("R10 ferr cleared", 3'd5, 8'h60);

        // R12 short low pulse rejected
        sin = 1'b0; repeat (4) @(negedge clk); sin = 1'b1;
        repeat (200) @(negedge clk);
        rd_chk("R12 glitch ignored", 3'd5, 8'h60);

        // R6 / R7 FIFO depth and order
        bus_wr(3'd2, 8'h07);
        for (int i = 0; i < 17; i++) ser_send(8'(i * 3 + 1), 1'b1);
        rd_chk("R6 lsr overrun", 3'd5, 8'h63);
        rd_chk("R6 entry 0", 3'd0, 8'd1);
        rd_chk("R7 still ready", 3'd5, 8'h61);
        for (int i = 1; i < 16; i++) rd_chk("R6 order", 3'd0, 8'(i * 3 + 1));
        rd_chk("R7 drained", 3'd5, 8'h60);

        // R11 trigger level and priority
        bus_wr(3'd2, 8'h41);
        bus_wr(3'd1, 8'h01);
        for (int i = 0; i < 3; i++) ser_send(8'h10, 1'b1);
        rd_chk("R11 below trigger", 3'd2, 8'hC1);
        chk("R11 irq low", {7'd0, irq}, 8'h00);
        ser_send(8'h11, 1'b1);
        rd_chk("R11 rx avail", 3'd2, 8'hC4);
        chk("R11 irq high", {7'd0, irq}, 8'h01);
        bus_wr(3'd1, 8'h03);
        rd_chk("R11 rx priority", 3'd2, 8'hC4);

        // R8 receive flush, then reception continues
        bus_wr(3'd2, 8'h43);
        rd_chk("R8 R11 tx empty", 3'd2, 8'hC2);
        rd_chk("R8 flushed", 3'd5, 8'h60);
        bus_wr(3'd1, 8'h00);
        rd_chk("R11 none", 3'd2, 8'hC1);
        ser_send(8'h77, 1'b1);
        rd_chk("R8 after clear", 3'd0, 8'h77);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule